// File: doc/BRIEF.md
# Transfer FIFO Status and Interrupt Unit

This block sits between a register-style host port and the serial shifter of a serial memory controller. It holds two byte FIFOs. The transmit FIFO is filled by the host and emptied by the shifter. It carries opcode, address, filler and payload bytes alike. The receive FIFO is filled by the shifter and emptied by the host through a single read-data port. Each FIFO has its own occupancy counter. These counters drive a five-bit status word and four raw interrupt sources. A mask turns the raw sources into masked sources and one interrupt line.

The host writes bytes into the transmit FIFO with a data strobe. Each read strobe pops one byte from the receive FIFO, so the host drains it by reading until the receive-not-empty flag drops. The host also programs two occupancy watermarks, a four-bit interrupt mask and a write-one-to-clear register for the latched sources. The shifter sees plain pop and push strobes, a one-cycle pulse per serial bit period and its own busy signal. All status and interrupt outputs are registered. They show the FIFO state that results from the strobes taken at the same clock edge.

Top module: `xfer_fifo_irq`

## Requirements
- R1: After a synchronous reset, the status word is 5'b00011, the raw interrupt vector is 4'b1000, and the masked vector and the interrupt line are zero.
- R2: Each FIFO holds 256 bytes and returns them in push order. A push into a full transmit FIFO is ignored. Popped data appears on the read-data output one clock after the pop strobe.
- R3: The status word places these flags: bit 0 transmit empty, bit 1 transmit not full, bit 2 receive not empty, bit 3 receive full.
- R4: The watermark write takes the transmit watermark from bits 6:0 and the receive watermark from bits 14:8. Both reset to 32.
- R5: Raw bit 2 is set exactly while receive occupancy is at or above the receive watermark.
- R6: Raw bit 3 is set exactly while transmit occupancy is at or below the transmit watermark.
- R7: A push into a full receive FIFO drops the byte and sets raw bit 0. The bit then stays set until it is cleared.
- R8: Raw bit 1 sets once 32 bit-period pulses have arrived with the receive FIFO non-empty and no receive push since the last push. It stays set until cleared, and it does not set again before a new push.
- R9: Writing a 1 into clear bit 0 or bit 1 clears the matching latched bit. A set event in the same cycle wins. The watermark bits are unaffected by the clear.
- R10: The masked vector equals the raw vector ANDed with the mask register. The interrupt line is the OR of the masked bits.
- R11: A host read while the receive FIFO is empty, or a shifter pop while the transmit FIFO is empty, changes no level or flag.
- R12: Status bit 4 (busy) is set while the transmit FIFO holds data or the shifter reports busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_we | input | 1 | Push host_wr_data into the transmit FIFO |
| host_wr_data | input | 8 | Transmit byte from host |
| host_rd_re | input | 1 | Pop one byte from the receive FIFO |
| host_rd_data | output | 8 | Byte popped by the last host read |
| thr_we | input | 1 | Load both watermarks |
| thr_wdata | input | 16 | Transmit watermark [6:0], receive watermark [14:8] |
| mask_we | input | 1 | Load the interrupt mask |
| mask_wdata | input | 4 | Interrupt mask |
| clr_we | input | 1 | Apply the clear word |
| clr_wdata | input | 4 | Bit 0 clears overrun, bit 1 clears timeout |
| sh_tx_pop | input | 1 | Shifter takes one transmit byte |
| sh_tx_data | output | 8 | Byte popped by the last shifter pop |
| sh_rx_push | input | 1 | Shifter delivers sh_rx_data |
| sh_rx_data | input | 8 | Received byte |
| sh_bit_tick | input | 1 | One pulse per serial bit period |
| sh_busy | input | 1 | Shifter activity |
| stat_o | output | 5 | Status word |
| raw_irq_o | output | 4 | Raw interrupt vector |
| masked_irq_o | output | 4 | Masked interrupt vector |
| irq_o | output | 1 | Interrupt line |

## Verification
The bound checker covers the invariants that hold on every cycle. Two flag pairs must agree: empty implies not full, and full implies not empty. A full receive FIFO or an empty transmit FIFO must show its watermark bit. The overrun and timeout bits may rise only after their cause and must stay latched until cleared. The masked vector must stay a subset of the raw vector, and busy must follow transmit occupancy. Data ordering, exact watermark crossings, the 32-pulse timeout count, clear behaviour and the default watermark values can only be shown by the bench. Its reference model tracks both queues on every clock through directed and random traffic.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
  localparam int DEPTH_DEF   = 256;
  localparam int WM_W_DEF    = 7;
  localparam int WM_RST      = 32;
  localparam int TO_BITS_DEF = 32;

  typedef struct packed {
    logic tx_wm;
    logic rx_wm;
    logic rx_to;
    logic rx_ovr;
  } irq_vec_t;

  typedef struct packed {
    logic busy;
    logic rx_full;
    logic rx_ne;
    logic tx_nf;
    logic tx_empty;
  } stat_t;
endpackage

// File: rtl/xfer_byte_fifo.sv
module xfer_byte_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level,
  output logic [LW-1:0] level_nxt
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign push_ok   = push && (level != LW'(DEPTH));
  assign pop_ok    = pop && (level != '0);
  assign level_nxt = level + LW'(push_ok) - LW'(pop_ok);

  // storage and registered read port, no reset so block RAM can be used
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
    if (pop_ok)  rd_data   <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      level <= level_nxt;
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end
  end
endmodule

// File: rtl/xfer_rx_timeout.sv
module xfer_rx_timeout #(
  parameter int TO_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic rx_push,
  input  logic rx_nonempty,
  output logic fire
);
  localparam int TW = $clog2(TO_BITS + 1);

  logic [TW-1:0] cnt;

  assign fire = bit_tick && !rx_push && rx_nonempty && (cnt == TW'(TO_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst || rx_push || !rx_nonempty) cnt <= '0;
    else if (bit_tick && cnt != TW'(TO_BITS)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/xfer_irq_status.sv
module xfer_irq_status
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WM_W  = 7,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LW-1:0]   tx_lvl_nxt,
  input  logic [LW-1:0]   rx_lvl_nxt,
  input  logic [WM_W-1:0] tx_thr_nxt,
  input  logic [WM_W-1:0] rx_thr_nxt,
  input  logic [3:0]      mask_nxt,
  input  logic            ovr_set,
  input  logic            to_set,
  input  logic            clr_ovr,
  input  logic            clr_to,
  input  logic            sh_busy,
  output stat_t           stat_q,
  output irq_vec_t        raw_q,
  output logic [3:0]      masked_q,
  output logic            irq_q
);
  irq_vec_t raw_d;
  stat_t    stat_d;

  always_comb begin
    raw_d.rx_ovr = ovr_set | (raw_q.rx_ovr & ~clr_ovr);
    raw_d.rx_to  = to_set  | (raw_q.rx_to  & ~clr_to);
    raw_d.rx_wm  = rx_lvl_nxt >= LW'(rx_thr_nxt);
    raw_d.tx_wm  = tx_lvl_nxt <= LW'(tx_thr_nxt);
    stat_d.tx_empty = (tx_lvl_nxt == '0);
    stat_d.tx_nf    = (tx_lvl_nxt != LW'(DEPTH));
    stat_d.rx_ne    = (rx_lvl_nxt != '0);
    stat_d.rx_full  = (rx_lvl_nxt == LW'(DEPTH));
    stat_d.busy     = (tx_lvl_nxt != '0) | sh_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q    <= irq_vec_t'(4'b1000);
      stat_q   <= stat_t'(5'b00011);
      masked_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      raw_q    <= raw_d;
      stat_q   <= stat_d;
      masked_q <= raw_d & mask_nxt;
      irq_q    <= |(raw_d & mask_nxt);
    end
  end
endmodule

// File: rtl/xfer_fifo_irq.sv
module xfer_fifo_irq
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH   = DEPTH_DEF,
  parameter int WM_W    = WM_W_DEF,
  parameter int TO_BITS = TO_BITS_DEF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr_we,
  input  logic [7:0]  host_wr_data,
  input  logic        host_rd_re,
  output logic [7:0]  host_rd_data,
  input  logic        thr_we,
  input  logic [15:0] thr_wdata,
  input  logic        mask_we,
  input  logic [3:0]  mask_wdata,
  input  logic        clr_we,
  input  logic [3:0]  clr_wdata,
  input  logic        sh_tx_pop,
  output logic [7:0]  sh_tx_data,
  input  logic        sh_rx_push,
  input  logic [7:0]  sh_rx_data,
  input  logic        sh_bit_tick,
  input  logic        sh_busy,
  output logic [4:0]  stat_o,
  output logic [3:0]  raw_irq_o,
  output logic [3:0]  masked_irq_o,
  output logic        irq_o
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic [LW-1:0]   tx_lvl, tx_lvl_nxt, rx_lvl, rx_lvl_nxt;
  logic [WM_W-1:0] tx_thr_q, rx_thr_q, tx_thr_d, rx_thr_d;
  logic [3:0]      mask_q, mask_d;
  logic            ovr_set, to_set;
  stat_t           stat_q;
  irq_vec_t        raw_q;
  logic            unused_bits;

  assign unused_bits = ^{thr_wdata[7], thr_wdata[15], clr_wdata[3:2]};

  xfer_byte_fifo #(.DEPTH(DEPTH), .DW(8), .LW(LW)) u_tx_fifo (
    .clk(clk), .rst(rst),
    .push(host_wr_we), .push_data(host_wr_data), .pop(sh_tx_pop),
    .rd_data(sh_tx_data), .level(tx_lvl), .level_nxt(tx_lvl_nxt)
  );

  xfer_byte_fifo #(.DEPTH(DEPTH), .DW(8), .LW(LW)) u_rx_fifo (
    .clk(clk), .rst(rst),
    .push(sh_rx_push), .push_data(sh_rx_data), .pop(host_rd_re),
    .rd_data(host_rd_data), .level(rx_lvl), .level_nxt(rx_lvl_nxt)
  );

  xfer_rx_timeout #(.TO_BITS(TO_BITS)) u_timeout (
    .clk(clk), .rst(rst), .bit_tick(sh_bit_tick), .rx_push(sh_rx_push),
    .rx_nonempty(rx_lvl != '0), .fire(to_set)
  );

  assign ovr_set = sh_rx_push && (rx_lvl == LW'(DEPTH));

  always_comb begin
    tx_thr_d = tx_thr_q;
    rx_thr_d = rx_thr_q;
    mask_d   = mask_q;
    if (thr_we) begin
      tx_thr_d = thr_wdata[WM_W-1:0];
      rx_thr_d = thr_wdata[8 +: WM_W];
    end
    if (mask_we) mask_d = mask_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr_q <= WM_W'(WM_RST);
      rx_thr_q <= WM_W'(WM_RST);
      mask_q   <= '0;
    end else begin
      tx_thr_q <= tx_thr_d;
      rx_thr_q <= rx_thr_d;
      mask_q   <= mask_d;
    end
  end

  xfer_irq_status #(.DEPTH(DEPTH), .WM_W(WM_W), .LW(LW)) u_irq (
    .clk(clk), .rst(rst),
    .tx_lvl_nxt(tx_lvl_nxt), .rx_lvl_nxt(rx_lvl_nxt),
    .tx_thr_nxt(tx_thr_d), .rx_thr_nxt(rx_thr_d), .mask_nxt(mask_d),
    .ovr_set(ovr_set), .to_set(to_set),
    .clr_ovr(clr_we & clr_wdata[0]), .clr_to(clr_we & clr_wdata[1]),
    .sh_busy(sh_busy),
    .stat_q(stat_q), .raw_q(raw_q), .masked_q(masked_irq_o), .irq_q(irq_o)
  );

  assign stat_o    = stat_q;
  assign raw_irq_o = raw_q;
endmodule

// File: rtl/xfer_fifo_irq_chk.sv
module xfer_fifo_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_push,
  input logic       clr_we,
  input logic [3:0] clr_bits,
  input logic [4:0] stat,
  input logic [3:0] raw,
  input logic [3:0] masked,
  input logic       irq
);
  assert_tx_flags_R3: assert property (@(posedge clk) disable iff (rst)
    stat[0] |-> stat[1]);
  assert_rx_flags_R3: assert property (@(posedge clk) disable iff (rst)
    stat[3] |-> stat[2]);
  assert_rx_full_wm_R5: assert property (@(posedge clk) disable iff (rst)
    stat[3] |-> raw[2]);
  assert_tx_empty_wm_R6: assert property (@(posedge clk) disable iff (rst)
    stat[0] |-> raw[3]);
  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (raw[0] && !(clr_we && clr_bits[0])) |=> raw[0]);
  assert_ovr_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(raw[0]) |-> $past(rx_push && stat[3]));
  assert_to_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(raw[1]) |-> $past(stat[2] && !rx_push));
  assert_to_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (raw[1] && !(clr_we && clr_bits[1])) |=> raw[1]);
  assert_mask_subset_R10: assert property (@(posedge clk) disable iff (rst)
    (masked & ~raw) == 4'b0000);
  assert_irq_line_R10: assert property (@(posedge clk) disable iff (rst)
    irq == (masked != 4'b0000));
  assert_busy_R12: assert property (@(posedge clk) disable iff (rst)
    !stat[0] |-> stat[4]);
endmodule

bind xfer_fifo_irq xfer_fifo_irq_chk u_chk (
  .clk(clk), .rst(rst), .rx_push(sh_rx_push), .clr_we(clr_we),
  .clr_bits(clr_wdata), .stat(stat_o), .raw(raw_irq_o),
  .masked(masked_irq_o), .irq(irq_o)
);

// File: tb/xfer_fifo_irq_tb.sv
module xfer_fifo_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr_we = 0, host_rd_re = 0, thr_we = 0, mask_we = 0, clr_we = 0;
  logic sh_tx_pop = 0, sh_rx_push = 0, sh_bit_tick = 0, sh_busy = 0;
  logic [7:0]  host_wr_data = 0, sh_rx_data = 0;
  logic [15:0] thr_wdata = 0;
  logic [3:0]  mask_wdata = 0, clr_wdata = 0;
  logic [7:0]  host_rd_data, sh_tx_data;
  logic [4:0]  stat_o;
  logic [3:0]  raw_irq_o, masked_irq_o;
  logic        irq_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xfer_fifo_irq u_dut (
    .clk(clk), .rst(rst),
    .host_wr_we(host_wr_we), .host_wr_data(host_wr_data),
    .host_rd_re(host_rd_re), .host_rd_data(host_rd_data),
    .thr_we(thr_we), .thr_wdata(thr_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data),
    .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data),
    .sh_bit_tick(sh_bit_tick), .sh_busy(sh_busy),
    .stat_o(stat_o), .raw_irq_o(raw_irq_o),
    .masked_irq_o(masked_irq_o), .irq_o(irq_o)
  );

  int checks = 0;
  int fails  = 0;

  // reference model
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int   tx_thr, rx_thr, to_cnt;
  logic [3:0] mask_m;
  logic ovr_m, to_m;
  logic [7:0] exp_rd, exp_txd;
  logic chk_rd, chk_txd;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    txq.delete(); rxq.delete();
    tx_thr = 32; rx_thr = 32; to_cnt = 0;
    mask_m = 0; ovr_m = 0; to_m = 0;
    chk_rd = 0; chk_txd = 0;
  endtask

  task automatic model_update();
    bit rx_full0, rx_ne0, set_to;
    rx_full0 = (rxq.size() == DEPTH);
    rx_ne0   = (rxq.size() != 0);
    set_to   = 0;
    if (sh_rx_push || !rx_ne0) to_cnt = 0;
    else if (sh_bit_tick && to_cnt < 32) begin
      to_cnt++;
      if (to_cnt == 32) set_to = 1;
    end
    if (clr_we && clr_wdata[0]) ovr_m = 0;
    if (clr_we && clr_wdata[1]) to_m = 0;
    if (sh_rx_push && rx_full0) ovr_m = 1;
    if (set_to) to_m = 1;
    chk_rd = 0; chk_txd = 0;
    if (host_rd_re && rx_ne0) begin exp_rd = rxq.pop_front(); chk_rd = 1; end
    if (sh_rx_push && !rx_full0) rxq.push_back(sh_rx_data);
    if (sh_tx_pop && txq.size() != 0) begin
      // tx full state must be taken before the pop for the push decision
      exp_txd = txq.pop_front(); chk_txd = 1;
      if (host_wr_we && txq.size() + 1 < DEPTH + 1 && txq.size() + 1 != DEPTH) txq.push_back(host_wr_data);
      else if (host_wr_we && txq.size() + 1 == DEPTH) ; // full at start: dropped
    end else if (host_wr_we && txq.size() != DEPTH) txq.push_back(host_wr_data);
    if (thr_we) begin tx_thr = thr_wdata[6:0]; rx_thr = thr_wdata[14:8]; end
    if (mask_we) mask_m = mask_wdata;
  endtask

  task automatic compare_all();
    logic [3:0] raw_e;
    raw_e = {txq.size() <= tx_thr, rxq.size() >= rx_thr, to_m, ovr_m};
    cmp("R3 status flags", stat_o[3:0],
        {rxq.size() == DEPTH, rxq.size() != 0, txq.size() != DEPTH, txq.size() == 0});
    cmp("R12 busy", stat_o[4], (txq.size() != 0) || sh_busy);
    cmp("R7 overrun bit", raw_irq_o[0], raw_e[0]);
    cmp("R8 timeout bit", raw_irq_o[1], raw_e[1]);
    cmp("R5 rx watermark", raw_irq_o[2], raw_e[2]);
    cmp("R6 tx watermark", raw_irq_o[3], raw_e[3]);
    cmp("R10 masked", masked_irq_o, raw_e & mask_m);
    cmp("R10 irq line", irq_o, |(raw_e & mask_m));
    if (chk_rd)  cmp("R2 rx data order", host_rd_data, exp_rd);
    if (chk_txd) cmp("R2 tx data order", sh_tx_data, exp_txd);
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
    host_wr_we = 0; host_rd_re = 0; thr_we = 0; mask_we = 0; clr_we = 0;
    sh_tx_pop = 0; sh_rx_push = 0; sh_bit_tick = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    cmp("R1 reset status", stat_o, 5'b00011);
    cmp("R1 reset raw", raw_irq_o, 4'b1000);
    cmp("R1 reset masked", masked_irq_o, 4'b0000);
    cmp("R1 reset irq", irq_o, 1'b0);

    // R11 pops on empty FIFOs change nothing
    host_rd_re = 1; sh_tx_pop = 1; step();
    cmp("R11 empty pops", stat_o, 5'b00011);

    // R4 default transmit watermark 32, R6 crossing
    for (int i = 0; i < 33; i++) begin
      host_wr_we = 1; host_wr_data = 8'(i * 7 + 1); step();
      if (i == 31) cmp("R4 tx default wm at 32", raw_irq_o[3], 1'b1);
    end
    cmp("R4 tx default wm at 33", raw_irq_o[3], 1'b0);

    // R2 fill transmit FIFO past full, then drain in order
    for (int i = 0; i < 230; i++) begin
      host_wr_we = 1; host_wr_data = 8'(i ^ 8'h5a); step();
    end
    cmp("R2 tx full", stat_o[1], 1'b0);
    for (int i = 0; i < 260; i++) begin
      sh_tx_pop = 1; sh_busy = (i < 100); step();
    end
    sh_busy = 0;

    // R4 default receive watermark, R5
    for (int i = 0; i < 32; i++) begin
      sh_rx_push = 1; sh_rx_data = 8'(i + 100); step();
      if (i == 30) cmp("R4 rx default wm at 31", raw_irq_o[2], 1'b0);
    end
    cmp("R4 rx default wm at 32", raw_irq_o[2], 1'b1);

    // R10 mask
    mask_we = 1; mask_wdata = 4'b0111; step();
    cmp("R10 irq from rx wm", irq_o, 1'b1);

    // R8 timeout: 31 pulses then the 32nd
    for (int i = 0; i < 31; i++) begin sh_bit_tick = 1; step(); end
    cmp("R8 no timeout at 31", raw_irq_o[1], 1'b0);
    sh_bit_tick = 1; step();
    cmp("R8 timeout at 32", raw_irq_o[1], 1'b1);
    clr_we = 1; clr_wdata = 4'b0010; step();
    cmp("R9 timeout cleared", raw_irq_o[1], 1'b0);
    for (int i = 0; i < 40; i++) begin sh_bit_tick = 1; step(); end
    cmp("R8 no re-arm without push", raw_irq_o[1], 1'b0);

    // R4 program watermarks: tx 5 in [6:0], rx 3 in [14:8]
    thr_we = 1; thr_wdata = {1'b0, 7'd3, 1'b0, 7'd5}; step();

    // R7 fill receive FIFO and overrun
    for (int i = 0; i < 226; i++) begin
      sh_rx_push = 1; sh_rx_data = 8'(i * 3); step();
    end
    cmp("R7 rx full", stat_o[3], 1'b1);
    cmp("R7 overrun set", raw_irq_o[0], 1'b1);
    clr_we = 1; clr_wdata = 4'b0001; step();
    cmp("R9 overrun cleared", raw_irq_o[0], 1'b0);
    cmp("R9 rx wm kept", raw_irq_o[2], 1'b1);

    // drain receive FIFO by reading until not-empty drops
    for (int i = 0; i < 258; i++) begin host_rd_re = 1; step(); end
    cmp("R2 rx drained", stat_o[2], 1'b0);

    // mixed random traffic
    void'($urandom(32'd17));
    for (int i = 0; i < 4000; i++) begin
      host_wr_we  = ($urandom % 2) == 0;
      host_wr_data = 8'($urandom);
      sh_tx_pop   = ($urandom % 5) < 2;
      sh_rx_push  = ($urandom % 10) < 3;
      sh_rx_data  = 8'($urandom);
      host_rd_re  = ($urandom % 5) < 2;
      sh_bit_tick = ($urandom % 2) == 0;
      sh_busy     = ($urandom % 3) == 0;
      clr_we      = ($urandom % 20) == 0;
      clr_wdata   = 4'($urandom);
      mask_we     = ($urandom % 20) == 0;
      mask_wdata  = 4'($urandom);
      thr_we      = ($urandom % 50) == 0;
      thr_wdata   = 16'($urandom);
      if (i > 2000 && i < 2300) host_rd_re = 0;
      step();
    end

    summary();
    $finish;
  end
endmodule